// File: doc/BRIEF.md
# Shared-Memory Cell Buffer Manager

This block keeps frames for several egress ports in one pool of fixed-size cells. The cell size is 64 bytes by default. A single ingress writer streams a frame one byte per cycle and tags it with a destination port. The manager takes a cell from a common free list whenever the frame crosses a cell boundary and chains the cells of a frame through a link RAM. When the final byte arrives, it places a frame descriptor on the FIFO of the destination port. The descriptor holds the first cell, the number of cells and the number of valid bytes in the last cell. No port has cells reserved for it. A busy port can therefore hold most of the pool while an idle port holds nothing.

A single read interface serves all egress ports. The transmitter picks a port with `rd_port` and pulls one byte per cycle with `rd_en`. Each port keeps its own read position, so reads of different ports may interleave. Once the last byte of a cell has been read, that cell goes back to the free list. If the pool has no cell for a byte that needs one, the frame is dropped. Cells it already holds go back to the pool in a single splice, and the rest of the frame is ignored. The drop counter shows these events, and `free_cells` shows how much of the pool is in use.

The write controller has three states. W_IDLE waits for a start byte. It moves to W_FILL when the first cell is taken and the frame continues. It moves to W_DISCARD when no cell is available and the frame continues. It stays in W_IDLE when a one-byte frame is committed or dropped at once. W_FILL returns to W_IDLE on the end byte, whether the frame is committed or dropped. W_FILL moves to W_DISCARD when the pool runs dry before the end byte. W_DISCARD returns to W_IDLE on the end byte.

Top module: `cbm_cell_buffer_mgr`

## Requirements
- R1: After reset, `free_cells` equals NUM_CELLS, `frame_avail` is all zero, `drop_count` is zero and `rd_valid` is low.
- R2: A stored frame of L bytes holds ceil(L/64) cells, and `free_cells` drops by one in the cycle after each byte that opens a new cell.
- R3: A frame's bit in `frame_avail` stays low while the frame is being written. It goes high in the cycle after the byte carrying `wr_eof` is accepted.
- R4: Reading a frame returns exactly its L bytes in write order, including a partly filled last cell. Each byte appears on `rd_data` with `rd_valid` one cycle after its `rd_en`. `rd_sof` marks the first byte and `rd_eof` marks the last.
- R5: Frames sent to one port are read out first in, first out. Frames waiting on other ports do not affect that order.
- R6: Each cell returns to the pool in the cycle after its last byte is read. After a whole frame is read, `free_cells` is back up by the frame's cell count.
- R7: If a byte needs a new cell while the pool is empty, the frame is dropped. The cells it already took return to the pool, `drop_count` rises by one, and its remaining bytes up to `wr_eof` are ignored. The frame never appears on `frame_avail`.
- R8: A frame whose first byte finds the pool empty is dropped without taking any cell, and `drop_count` rises by one.
- R9: A cell freed by the reader and a cell taken by the writer in the same cycle both take effect. `free_cells` is then unchanged, and the frames written and read through such cycles keep correct data. This also holds when only one cell is free.
- R10: `rd_en` on a port with no stored frame produces no `rd_valid` and changes neither `free_cells` nor `frame_avail`.
- R11: `free_cells` never exceeds NUM_CELLS. After all stored frames are read, a single frame that needs every cell of the pool is stored and read back intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Ingress byte valid |
| wr_sof | input | 1 | Byte is the first of a frame |
| wr_eof | input | 1 | Byte is the last of a frame |
| wr_port | input | PW | Destination port, sampled with the first byte |
| wr_data | input | DATA_W | Ingress byte |
| rd_en | input | 1 | Pull one byte from the selected port |
| rd_port | input | PW | Egress port being read |
| rd_valid | output | 1 | Read byte valid |
| rd_data | output | DATA_W | Read byte |
| rd_sof | output | 1 | Read byte is first of its frame |
| rd_eof | output | 1 | Read byte is last of its frame |
| frame_avail | output | NUM_PORTS | One bit per port: at least one complete frame queued |
| free_cells | output | NW | Number of cells in the free pool |
| drop_pulse | output | 1 | One-cycle pulse per dropped frame |
| drop_count | output | DROP_W | Number of dropped frames |

## Verification
The hardest case to reach is a cycle in which the reader frees a cell while the writer takes one and only one cell is free. In that cycle the free-list head, tail and link all change together. To reach it, the bench first fills the pool so that exactly two cells are free. It then starts a frame on one port and, one cycle later, starts reading a four-cell frame on another port. Because of the one-cycle offset, every cell boundary of the read falls in the same cycle as a cell boundary of the write. The bench checks the free count after this run. It then reads every frame back and stores and reads a frame that needs the whole pool, so any corruption of the list shows up in the data.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
    typedef enum logic [1:0] {
        W_IDLE    = 2'd0,
        W_FILL    = 2'd1,
        W_DISCARD = 2'd2
    } wr_state_e;
endpackage

// File: rtl/cbm_free_list.sv
module cbm_free_list #(
    parameter  int NUM_CELLS = 16,
    localparam int CW        = $clog2(NUM_CELLS),
    localparam int NW        = $clog2(NUM_CELLS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_en,
    output logic [CW-1:0] alloc_cell,
    output logic          avail,
    input  logic          rel_en,
    input  logic [CW-1:0] rel_cell,
    input  logic          sp_en,
    input  logic [CW-1:0] sp_head,
    input  logic [CW-1:0] sp_tail,
    input  logic [NW-1:0] sp_cnt,
    input  logic          lw_en,
    input  logic [CW-1:0] lw_addr,
    input  logic [CW-1:0] lw_data,
    input  logic [CW-1:0] lr_addr,
    output logic [CW-1:0] lr_data,
    output logic [NW-1:0] free_cnt
);
    logic [CW-1:0] link [NUM_CELLS];
    logic [CW-1:0] head, tail;
    logic [NW-1:0] count, left;
    logic          app_en;
    logic [CW-1:0] app_first, app_last;
    logic [NW-1:0] app_n;

    assign alloc_cell = head;
    assign avail      = (count != '0);
    assign free_cnt   = count;
    assign lr_data    = link[lr_addr];
    assign left       = count - {{(NW-1){1'b0}}, alloc_en};

    // The reader's cell goes first, followed by a spliced chain if one arrives too.
    always_comb begin
        app_en    = rel_en | sp_en;
        app_first = rel_en ? rel_cell : sp_head;
        app_last  = sp_en ? sp_tail : rel_cell;
        app_n     = (sp_en ? sp_cnt : '0) + {{(NW-1){1'b0}}, rel_en};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CELLS; i++) link[i] <= CW'((i + 1) % NUM_CELLS);
            head  <= '0;
            tail  <= CW'(NUM_CELLS - 1);
            count <= NW'(NUM_CELLS);
        end else begin
            if (lw_en) link[lw_addr] <= lw_data;
            if (rel_en && sp_en) link[rel_cell] <= sp_head;
            if (alloc_en) head <= link[head];
            if (app_en) begin
                if (left == '0) head <= app_first;
                else            link[tail] <= app_first;
                tail <= app_last;
            end
            count <= left + app_n;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= NW'(NUM_CELLS)); // R11
    AST_ALLOC_NEEDS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> count != '0); // R8
    AST_ALLOC_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_en && count > NW'(1)) |=> alloc_cell != $past(alloc_cell)); // R9
endmodule

// File: rtl/cbm_frame_fifo.sv
module cbm_frame_fifo #(
    parameter  int DEPTH = 16,
    parameter  int W     = 8,
    localparam int PTRW  = $clog2(DEPTH),
    localparam int CNTW  = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         not_empty
);
    logic [W-1:0]    store [DEPTH];
    logic [PTRW-1:0] wp, rp;
    logic [CNTW-1:0] cnt;

    assign dout      = store[rp];
    assign not_empty = (cnt != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) begin
                store[wp] <= din;
                wp <= (wp == PTRW'(DEPTH - 1)) ? '0 : wp + PTRW'(1);
            end
            if (pop) rp <= (rp == PTRW'(DEPTH - 1)) ? '0 : rp + PTRW'(1);
            cnt <= cnt + CNTW'(push) - CNTW'(pop);
        end
    end

    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> cnt < CNTW'(DEPTH)); // R5
    AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> cnt != '0); // R10
endmodule

// File: rtl/cbm_cell_buffer_mgr.sv
module cbm_cell_buffer_mgr
    import cbm_pkg::*;
#(
    parameter  int NUM_PORTS  = 4,
    parameter  int NUM_CELLS  = 16,
    parameter  int CELL_BYTES = 64,
    parameter  int DATA_W     = 8,
    parameter  int DROP_W     = 16,
    localparam int PW         = $clog2(NUM_PORTS),
    localparam int CW         = $clog2(NUM_CELLS),
    localparam int NW         = $clog2(NUM_CELLS + 1),
    localparam int OW         = $clog2(CELL_BYTES),
    localparam int BW         = $clog2(CELL_BYTES + 1),
    localparam int DESC_W     = CW + NW + BW,
    localparam int MEM_D      = NUM_CELLS * CELL_BYTES,
    localparam int AW         = $clog2(MEM_D)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_valid,
    input  logic                 wr_sof,
    input  logic                 wr_eof,
    input  logic [PW-1:0]        wr_port,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 rd_en,
    input  logic [PW-1:0]        rd_port,
    output logic                 rd_valid,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_sof,
    output logic                 rd_eof,
    output logic [NUM_PORTS-1:0] frame_avail,
    output logic [NW-1:0]        free_cells,
    output logic                 drop_pulse,
    output logic [DROP_W-1:0]    drop_count
);
    // ---------------- shared storage ----------------
    logic [DATA_W-1:0] mem [MEM_D];

    // ---------------- free list ----------------
    logic          alloc_en, fl_avail, rel_en, sp_en, lw_en;
    logic [CW-1:0] fl_cell, rel_cell, lw_addr, lw_data, lr_addr, lr_data;

    // ---------------- writer state ----------------
    wr_state_e      wr_state, wr_state_n;
    logic [CW-1:0]  w_head, w_cur, wcell;
    logic [OW-1:0]  w_off, woff;
    logic [NW-1:0]  w_ncells;
    logic [PW-1:0]  w_port, push_port;
    logic           mem_we, push_en, drop_now;
    logic [DESC_W-1:0] push_desc;

    // ---------------- reader state ----------------
    logic [NUM_PORTS-1:0] push_vec, pop_vec;
    logic [DESC_W-1:0]    q_dout [NUM_PORTS];
    logic                 r_mid  [NUM_PORTS];
    logic [CW-1:0]        r_cell [NUM_PORTS];
    logic [OW-1:0]        r_off  [NUM_PORTS];
    logic [NW-1:0]        r_left [NUM_PORTS];
    logic [CW-1:0]        d_head, cur_cell;
    logic [NW-1:0]        d_ncell, cur_left;
    logic [BW-1:0]        d_bytes;
    logic [OW-1:0]        cur_off;
    logic                 rd_go, frame_end, cell_end;

    cbm_free_list #(.NUM_CELLS(NUM_CELLS)) u_free (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(alloc_en), .alloc_cell(fl_cell), .avail(fl_avail),
        .rel_en(rel_en), .rel_cell(rel_cell),
        .sp_en(sp_en), .sp_head(w_head), .sp_tail(w_cur), .sp_cnt(w_ncells),
        .lw_en(lw_en), .lw_addr(lw_addr), .lw_data(lw_data),
        .lr_addr(lr_addr), .lr_data(lr_data), .free_cnt(free_cells)
    );

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_q
        cbm_frame_fifo #(.DEPTH(NUM_CELLS), .W(DESC_W)) u_q (
            .clk(clk), .rst_n(rst_n),
            .push(push_vec[g]), .din(push_desc),
            .pop(pop_vec[g]), .dout(q_dout[g]), .not_empty(frame_avail[g])
        );
    end

    // ---------------- writer: state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) wr_state <= W_IDLE;
        else        wr_state <= wr_state_n;
    end

    // ---------------- writer: next state and controls ----------------
    always_comb begin
        wr_state_n = wr_state;
        alloc_en   = 1'b0;
        mem_we     = 1'b0;
        lw_en      = 1'b0;
        lw_addr    = w_cur;
        lw_data    = fl_cell;
        sp_en      = 1'b0;
        push_en    = 1'b0;
        push_port  = w_port;
        push_desc  = '0;
        drop_now   = 1'b0;
        wcell      = w_cur;
        woff       = '0;
        unique case (wr_state)
            W_IDLE: begin
                if (wr_valid && wr_sof) begin
                    push_port = wr_port;
                    if (fl_avail) begin
                        alloc_en = 1'b1;
                        mem_we   = 1'b1;
                        wcell    = fl_cell;
                        if (wr_eof) begin
                            push_en   = 1'b1;
                            push_desc = {fl_cell, NW'(1), BW'(1)};
                        end else begin
                            wr_state_n = W_FILL;
                        end
                    end else begin
                        drop_now = 1'b1;
                        if (!wr_eof) wr_state_n = W_DISCARD;
                    end
                end
            end
            W_FILL: begin
                if (wr_valid) begin
                    if (w_off == OW'(CELL_BYTES - 1)) begin
                        if (fl_avail) begin
                            alloc_en = 1'b1;
                            lw_en    = 1'b1;
                            mem_we   = 1'b1;
                            wcell    = fl_cell;
                            if (wr_eof) begin
                                push_en    = 1'b1;
                                push_desc  = {w_head, w_ncells + NW'(1), BW'(1)};
                                wr_state_n = W_IDLE;
                            end
                        end else begin
                            sp_en      = 1'b1;
                            drop_now   = 1'b1;
                            wr_state_n = wr_eof ? W_IDLE : W_DISCARD;
                        end
                    end else begin
                        mem_we = 1'b1;
                        woff   = w_off + OW'(1);
                        if (wr_eof) begin
                            push_en    = 1'b1;
                            push_desc  = {w_head, w_ncells, BW'(w_off) + BW'(2)};
                            wr_state_n = W_IDLE;
                        end
                    end
                end
            end
            W_DISCARD: begin
                if (wr_valid && wr_eof) wr_state_n = W_IDLE;
            end
            default: wr_state_n = W_IDLE;
        endcase
    end

    // ---------------- writer datapath ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_head     <= '0;
            w_cur      <= '0;
            w_off      <= '0;
            w_ncells   <= '0;
            w_port     <= '0;
            drop_pulse <= 1'b0;
            drop_count <= '0;
        end else begin
            drop_pulse <= drop_now;
            if (drop_now) drop_count <= drop_count + DROP_W'(1);
            if (mem_we) begin
                w_off <= woff;
                if (alloc_en) begin
                    w_cur <= fl_cell;
                    if (wr_state == W_IDLE) begin
                        w_head   <= fl_cell;
                        w_ncells <= NW'(1);
                        w_port   <= wr_port;
                    end else begin
                        w_ncells <= w_ncells + NW'(1);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (mem_we) mem[AW'(wcell) * AW'(CELL_BYTES) + AW'(woff)] <= wr_data;
    end

    // ---------------- reader ----------------
    always_comb begin
        d_head    = q_dout[rd_port][DESC_W-1 -: CW];
        d_ncell   = q_dout[rd_port][BW+NW-1 -: NW];
        d_bytes   = q_dout[rd_port][BW-1:0];
        cur_cell  = r_mid[rd_port] ? r_cell[rd_port] : d_head;
        cur_left  = r_mid[rd_port] ? r_left[rd_port] : d_ncell;
        cur_off   = r_mid[rd_port] ? r_off[rd_port]  : '0;
        rd_go     = rd_en && frame_avail[rd_port];
        frame_end = (cur_left == NW'(1)) && (BW'(cur_off) == d_bytes - BW'(1));
        cell_end  = frame_end || (cur_off == OW'(CELL_BYTES - 1));
        rel_en    = rd_go && cell_end;
        rel_cell  = cur_cell;
        lr_addr   = cur_cell;
        for (int p = 0; p < NUM_PORTS; p++) begin
            push_vec[p] = push_en && (push_port == PW'(p));
            pop_vec[p]  = rd_go && frame_end && (rd_port == PW'(p));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                r_mid[p]  <= 1'b0;
                r_cell[p] <= '0;
                r_off[p]  <= '0;
                r_left[p] <= '0;
            end
            rd_valid <= 1'b0;
            rd_sof   <= 1'b0;
            rd_eof   <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_go;
            rd_sof   <= rd_go && !r_mid[rd_port];
            rd_eof   <= rd_go && frame_end;
            if (rd_go) begin
                rd_data <= mem[AW'(cur_cell) * AW'(CELL_BYTES) + AW'(cur_off)];
                if (frame_end) begin
                    r_mid[rd_port] <= 1'b0;
                end else begin
                    r_mid[rd_port] <= 1'b1;
                    if (cell_end) begin
                        r_cell[rd_port] <= lr_data;
                        r_off[rd_port]  <= '0;
                        r_left[rd_port] <= cur_left - NW'(1);
                    end else begin
                        r_cell[rd_port] <= cur_cell;
                        r_off[rd_port]  <= cur_off + OW'(1);
                        r_left[rd_port] <= cur_left;
                    end
                end
            end
        end
    end

    AST_RD_VALID_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_en)); // R10
    AST_EOF_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_eof || rd_sof) |-> rd_valid); // R4
    AST_SPLICE_FROM_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        sp_en |=> wr_state != W_FILL); // R7
    AST_DROP_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
        drop_pulse |-> drop_count == $past(drop_count) + DROP_W'(1)); // R8
endmodule

// File: tb/cbm_cell_buffer_mgr_tb.sv
`timescale 1ns/1ps
module cbm_cell_buffer_mgr_tb_top;
    localparam int NP = 4;
    localparam int NC = 16;
    localparam int CB = 64;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_valid, wr_sof, wr_eof;
    logic [1:0]  wr_port;
    logic [7:0]  wr_data;
    logic        rd_en;
    logic [1:0]  rd_port;
    logic        rd_valid, rd_sof, rd_eof;
    logic [7:0]  rd_data;
    logic [3:0]  frame_avail;
    logic [4:0]  free_cells;
    logic        drop_pulse;
    logic [15:0] drop_count;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    cbm_cell_buffer_mgr dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_sof(wr_sof), .wr_eof(wr_eof),
        .wr_port(wr_port), .wr_data(wr_data),
        .rd_en(rd_en), .rd_port(rd_port),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_sof(rd_sof), .rd_eof(rd_eof),
        .frame_avail(frame_avail), .free_cells(free_cells),
        .drop_pulse(drop_pulse), .drop_count(drop_count)
    );

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 37) + (i * 11) + (i >> 6));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    task automatic send(input int port, input int len, input int seed, input bit chk_hidden);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (chk_hidden && i == len - 1)
                chk(frame_avail[port] == 1'b0, "R3 hidden before last byte", frame_avail[port], 0);
            wr_valid = 1'b1;
            wr_sof   = (i == 0);
            wr_eof   = (i == len - 1);
            wr_port  = 2'(port);
            wr_data  = pat(seed, i);
        end
        @(negedge clk);
        wr_valid = 1'b0; wr_sof = 1'b0; wr_eof = 1'b0;
    endtask

    task automatic recv(input int port, input int len, input int seed, input string req);
        int errs = 0;
        int first_act = 0, first_exp = 0;
        int mark_err = 0;
        for (int i = 0; i <= len; i++) begin
            @(negedge clk);
            if (i > 0) begin
                if (!rd_valid || rd_data != pat(seed, i - 1)) begin
                    if (errs == 0) begin first_act = rd_data; first_exp = pat(seed, i - 1); end
                    errs++;
                end
                if (rd_sof != (i == 1) || rd_eof != (i == len)) mark_err++;
            end
            rd_en   = (i < len);
            rd_port = 2'(port);
        end
        rd_en = 1'b0;
        chk(errs == 0, {req, " data"}, first_act, first_exp);
        chk(mark_err == 0, "R4 sof/eof marks", mark_err, 0);
    endtask

    task automatic t_reset();
        chk(free_cells == 5'(NC), "R1 free_cells", free_cells, NC);
        chk(frame_avail == 4'b0, "R1 frame_avail", frame_avail, 0);
        chk(drop_count == 16'd0, "R1 drop_count", drop_count, 0);
        chk(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
    endtask

    task automatic t_single();
        send(1, 100, 3, 1'b1);
        chk(frame_avail[1] == 1'b1, "R3 visible after eof", frame_avail[1], 1);
        chk(free_cells == 5'(NC - 2), "R2 two cells held", free_cells, NC - 2);
        recv(1, 100, 3, "R4 100-byte frame");
        chk(free_cells == 5'(NC), "R6 cells returned", free_cells, NC);
        chk(frame_avail[1] == 1'b0, "R6 queue emptied", frame_avail[1], 0);
    endtask

    task automatic t_sizes();
        send(0, 64, 5, 1'b0);
        chk(free_cells == 5'(NC - 1), "R2 full cell", free_cells, NC - 1);
        send(0, 1, 6, 1'b0);
        send(0, 65, 7, 1'b0);
        chk(free_cells == 5'(NC - 4), "R2 1+1+2 cells", free_cells, NC - 4);
        recv(0, 64, 5, "R4 exact cell");
        recv(0, 1, 6, "R4 one byte");
        recv(0, 65, 7, "R4 one over cell");
        chk(free_cells == 5'(NC), "R6 all back", free_cells, NC);
    endtask

    task automatic t_order();
        send(2, 10, 11, 1'b0);
        send(3, 40, 12, 1'b0);
        send(2, 70, 13, 1'b0);
        send(2, 5, 14, 1'b0);
        recv(3, 40, 12, "R5 other port");
        recv(2, 10, 11, "R5 first");
        recv(2, 70, 13, "R5 second");
        recv(2, 5, 14, "R5 third");
        chk(free_cells == 5'(NC), "R6 after order", free_cells, NC);
    endtask

    task automatic t_empty_read();
        int seen = 0;
        send(1, 20, 21, 1'b0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (rd_valid) seen++;
            rd_en = 1'b1; rd_port = 2'd0;
        end
        @(negedge clk);
        if (rd_valid) seen++;
        rd_en = 1'b0;
        @(negedge clk);
        chk(seen == 0, "R10 no rd_valid", seen, 0);
        chk(free_cells == 5'(NC - 1), "R10 pool unchanged", free_cells, NC - 1);
        chk(frame_avail == 4'b0010, "R10 avail unchanged", frame_avail, 2);
        recv(1, 20, 21, "R10 other frame intact");
    endtask

    task automatic t_dry();
        int d0;
        d0 = drop_count;
        send(0, 15 * CB, 31, 1'b0);
        chk(free_cells == 5'd1, "R2 fifteen cells", free_cells, 1);
        send(1, 130, 32, 1'b0);
        chk(drop_count == 16'(d0 + 1), "R7 drop counted", drop_count, d0 + 1);
        chk(free_cells == 5'd1, "R7 cells returned", free_cells, 1);
        chk(frame_avail[1] == 1'b0, "R7 frame hidden", frame_avail[1], 0);
        send(1, 64, 33, 1'b0);
        chk(free_cells == 5'd0, "R2 pool empty", free_cells, 0);
        send(2, 10, 34, 1'b0);
        chk(drop_count == 16'(d0 + 2), "R8 drop counted", drop_count, d0 + 2);
        chk(frame_avail[2] == 1'b0, "R8 frame hidden", frame_avail[2], 0);
        chk(free_cells == 5'd0, "R8 no cell taken", free_cells, 0);
        recv(1, 64, 33, "R7 following frame");
        recv(0, 15 * CB, 31, "R7 large frame");
        chk(free_cells == 5'(NC), "R6 after dry", free_cells, NC);
    endtask

    task automatic t_overlap();
        send(2, 10 * CB, 41, 1'b0);
        send(0, 4 * CB, 42, 1'b0);
        chk(free_cells == 5'd2, "R9 setup", free_cells, 2);
        fork
            send(1, 5 * CB, 43, 1'b0);
            begin
                @(negedge clk);
                recv(0, 4 * CB, 42, "R9 frame read during write");
            end
        join
        chk(free_cells == 5'd1, "R9 count after overlap", free_cells, 1);
        recv(1, 5 * CB, 43, "R9 frame written during read");
        recv(2, 10 * CB, 41, "R9 filler frame");
        chk(free_cells == 5'(NC), "R11 pool restored", free_cells, NC);
        send(3, NC * CB, 44, 1'b0);
        chk(free_cells == 5'd0, "R11 whole pool used", free_cells, 0);
        recv(3, NC * CB, 44, "R11 pool-sized frame");
        chk(free_cells == 5'(NC), "R11 final count", free_cells, NC);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        rst_n = 1'b0;
        wr_valid = 1'b0; wr_sof = 1'b0; wr_eof = 1'b0; wr_port = '0; wr_data = '0;
        rd_en = 1'b0; rd_port = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_sizes();
        t_order();
        t_empty_read();
        t_dry();
        t_overlap();
        summary();
    end
endmodule